// File: doc/BRIEF.md
# Module Reset and Clock-Enable Sequencer

This block owns a two-bit control register for one downstream module. One bit holds the module in soft reset and the other gates its clock. Software reaches the register through a simple write port at three offsets. One offset replaces the bits, one ORs a mask into them, and one clears the masked bits. The readback of the soft-reset bit stays high for a short settling time after the bit is cleared. While soft reset is held and the downstream module acknowledges that the reset has taken hold, hardware forces the clock-gate bit on. Software can therefore see the reset complete.

On a start pulse, a small sequencer performs the bring-up procedure through the same register. It releases soft reset and polls until the release reads back. It ungates the clock. In full mode it then asserts soft reset and polls for the acknowledging clock-gate bit. It releases soft reset again and polls. Last, it ungates the clock and polls until the gate reads clear. In enable-only mode the assert-and-poll step is left out, so the module is enabled without being reset. Each poll gives up after a fixed number of tries and raises a sticky timeout flag. A successful run ends with a one-cycle done pulse. Bus writes and further start pulses are ignored while a run is in progress.

Top module: `modrst_seq`

## Requirements
- R1: After reset, `bus_rdata` reads 0xC000_0000 (bit 31 = soft reset, bit 30 = clock gate, all other bits 0), `mod_rst` is 1, `mod_clk_en` is 0, and `done` and `timeout_err` are 0.
- R2: A write at byte offset 0x0 loads bits 31 and 30 from `bus_wdata`. A write at 0x4 ORs those two bits of `bus_wdata` into the register. A write at 0x8 clears the bits that are 1 in `bus_wdata`. A write at 0xC has no effect. All other bits always read 0. `mod_rst` follows bit 31 and `mod_clk_en` is the inverse of bit 30.
- R3: After the soft-reset bit goes from 1 to 0, its readback in `bus_rdata[31]` stays 1 for exactly 3 more clock cycles.
- R4: At any clock edge where the soft-reset bit is 1 and `rst_ack` is 1, the clock-gate bit becomes 1. This hardware set takes priority over a bus write that clears it.
- R5: In full mode (`enable_only` = 0), the steps run in this order: release reset and poll; ungate; assert reset and poll for the gate; release and poll; ungate and poll. Let edge 0 be the edge that samples `start`, S = 3 if soft reset was 1 at start (else 0), and D the number of cycles `rst_ack` lags `mod_rst`. Then `done` is high after edge 13+S+D.
- R6: In enable-only mode, `mod_rst` never rises during the run, and `done` is high after edge 7+S.
- R7: After `done`, both control bits read 0, `mod_rst` is 0 and `mod_clk_en` is 1.
- R8: Each poll makes at most 1024 tries. If a poll fails, `timeout_err` rises and no `done` is given. If `rst_ack` is withheld in full mode, the flag is high after edge 4+S+1024. The flag stays set until the next accepted start, which clears it.
- R9: While a run is in progress, bus writes and start pulses have no effect.
- R10: `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset: 0x0 write, 0x4 set, 0x8 clear |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Control register readback |
| start | input | 1 | Pulse to begin the enable/reset procedure |
| enable_only | input | 1 | Sampled with start: skip the reset step |
| done | output | 1 | One-cycle pulse on successful completion |
| timeout_err | output | 1 | Sticky flag: a poll ran out of tries |
| rst_ack | input | 1 | Downstream module reports its reset took hold |
| mod_rst | output | 1 | Soft reset to the downstream module |
| mod_clk_en | output | 1 | Clock enable to the downstream module |

## Verification
The hardest case to reach is the poll timeout. A correct downstream module always acknowledges, so the bench's stand-in for that module has a switch that withholds `rst_ack`. The run then sits in the gate poll for the full 1024 tries. Bus writes and a second start pulse are injected during that long wait, which shows they are ignored. The normal runs sweep the acknowledge lag and the initial soft-reset state, so the settle wait and the gate poll each have to last an exactly known number of cycles.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int OFS_WRITE = 'h0;
  localparam int OFS_SET   = 'h4;
  localparam int OFS_CLEAR = 'h8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2
  } reg_op_e;

  typedef struct packed {
    reg_op_e op;
    logic    srst;
    logic    gate;
  } reg_cmd_t;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_CLR_SR,
    SQ_W_SR0,
    SQ_CLR_CG,
    SQ_SET_SR,
    SQ_W_CG1,
    SQ_REL_SR,
    SQ_W_SR0B,
    SQ_REL_CG,
    SQ_W_CG0
  } seq_state_e;

endpackage

// File: rtl/rsc_ctrl_reg.sv
module rsc_ctrl_reg
  import rsc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int SETTLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              lock,
  input  reg_cmd_t          seq_cmd,
  input  logic              rst_ack,
  output logic [DATA_W-1:0] rdata,
  output logic              srst_q,
  output logic              gate_q,
  output logic              srst_view
);

  localparam int SR_BIT = DATA_W - 1;
  localparam int CG_BIT = DATA_W - 2;
  localparam int SET_W  = $clog2(SETTLE_CYC + 1);
  localparam logic [ADDR_W-1:0] A_WRITE = ADDR_W'(OFS_WRITE);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);

  logic             wr_ok;
  logic             srst_n, gate_n;
  logic [SET_W-1:0] settle_q;

  assign wr_ok = bus_wr && !lock;

  always_comb begin
    srst_n = srst_q;
    gate_n = gate_q;
    if (wr_ok) begin
      if (bus_addr == A_WRITE) begin
        srst_n = bus_wdata[SR_BIT];
        gate_n = bus_wdata[CG_BIT];
      end else if (bus_addr == A_SET) begin
        srst_n = srst_q | bus_wdata[SR_BIT];
        gate_n = gate_q | bus_wdata[CG_BIT];
      end else if (bus_addr == A_CLEAR) begin
        srst_n = srst_q & ~bus_wdata[SR_BIT];
        gate_n = gate_q & ~bus_wdata[CG_BIT];
      end
    end else begin
      case (seq_cmd.op)
        OP_SET: begin
          srst_n = srst_q | seq_cmd.srst;
          gate_n = gate_q | seq_cmd.gate;
        end
        OP_CLR: begin
          srst_n = srst_q & ~seq_cmd.srst;
          gate_n = gate_q & ~seq_cmd.gate;
        end
        default: ;
      endcase
    end
    // reset acknowledged by the module: hardware sets the gate
    if (srst_q && rst_ack) gate_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q   <= 1'b1;
      gate_q   <= 1'b1;
      settle_q <= '0;
    end else begin
      srst_q <= srst_n;
      gate_q <= gate_n;
      if (srst_q && !srst_n)   settle_q <= SET_W'(SETTLE_CYC);
      else if (settle_q != '0) settle_q <= settle_q - 1'b1;
    end
  end

  assign srst_view = srst_q || (settle_q != '0);

  always_comb begin
    rdata         = '0;
    rdata[SR_BIT] = srst_view;
    rdata[CG_BIT] = gate_q;
  end

  a_r4_hw_gate_set: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && rst_ack) |=> gate_q);

  a_r3_settle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_q) |-> srst_view);

  a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ok, seq_cmd.op != OP_NONE}));

endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
  import rsc_pkg::*;
#(
  parameter int POLL_LIMIT = 1024
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     enable_only,
  input  logic     srst_view,
  input  logic     gate_bit,
  output reg_cmd_t cmd,
  output logic     busy,
  output logic     done,
  output logic     timeout_err
);

  localparam int CNT_W = (POLL_LIMIT > 2) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST_TRY = CNT_W'(POLL_LIMIT - 1);

  seq_state_e       st, after;
  logic [CNT_W-1:0] cnt;
  logic             eo_q, done_q, err_q;
  logic             waiting, met;

  always_comb begin
    waiting = 1'b1;
    met     = 1'b0;
    after   = SQ_IDLE;
    case (st)
      SQ_W_SR0:  begin met = !srst_view; after = SQ_CLR_CG; end
      SQ_W_CG1:  begin met = gate_bit;   after = SQ_REL_SR; end
      SQ_W_SR0B: begin met = !srst_view; after = SQ_REL_CG; end
      SQ_W_CG0:  begin met = !gate_bit;  after = SQ_IDLE;   end
      default:   waiting = 1'b0;
    endcase
  end

  always_comb begin
    cmd = '{op: OP_NONE, srst: 1'b0, gate: 1'b0};
    case (st)
      SQ_CLR_SR, SQ_REL_SR: cmd = '{op: OP_CLR, srst: 1'b1, gate: 1'b0};
      SQ_CLR_CG, SQ_REL_CG: cmd = '{op: OP_CLR, srst: 1'b0, gate: 1'b1};
      SQ_SET_SR:            cmd = '{op: OP_SET, srst: 1'b1, gate: 1'b0};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      cnt    <= '0;
      eo_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (waiting) begin
        if (met) begin
          st  <= after;
          cnt <= '0;
          if (st == SQ_W_CG0) done_q <= 1'b1;
        end else if (cnt == LAST_TRY) begin
          st    <= SQ_IDLE;
          cnt   <= '0;
          err_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        case (st)
          SQ_IDLE: if (start) begin
            st    <= SQ_CLR_SR;
            eo_q  <= enable_only;
            err_q <= 1'b0;
            cnt   <= '0;
          end
          SQ_CLR_SR: st <= SQ_W_SR0;
          SQ_CLR_CG: st <= eo_q ? SQ_REL_SR : SQ_SET_SR;
          SQ_SET_SR: st <= SQ_W_CG1;
          SQ_REL_SR: st <= SQ_W_SR0B;
          SQ_REL_CG: st <= SQ_W_CG0;
          default:   st <= SQ_IDLE;
        endcase
      end
    end
  end

  assign busy        = (st != SQ_IDLE);
  assign done        = done_q;
  assign timeout_err = err_q;

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_no_done_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !timeout_err);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !(start && !busy)) |=> timeout_err);

  a_r6_enonly_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eo_q) |-> (cmd.op != OP_SET));

endmodule

// File: rtl/modrst_seq.sv
module modrst_seq #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int SETTLE_CYC = 3,
  parameter int POLL_LIMIT = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              start,
  input  logic              enable_only,
  output logic              done,
  output logic              timeout_err,
  input  logic              rst_ack,
  output logic              mod_rst,
  output logic              mod_clk_en
);

  rsc_pkg::reg_cmd_t seq_cmd;
  logic busy, srst_q, gate_q, srst_view;

  rsc_ctrl_reg #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE_CYC)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .lock(busy), .seq_cmd(seq_cmd),
    .rst_ack(rst_ack), .rdata(bus_rdata), .srst_q(srst_q),
    .gate_q(gate_q), .srst_view(srst_view)
  );

  rsc_seq #(.POLL_LIMIT(POLL_LIMIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .enable_only(enable_only),
    .srst_view(srst_view), .gate_bit(gate_q), .cmd(seq_cmd),
    .busy(busy), .done(done), .timeout_err(timeout_err)
  );

  assign mod_rst    = srst_q;
  assign mod_clk_en = !gate_q;

endmodule

// File: tb/modrst_seq_tb.sv
module modrst_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        start = 1'b0, enable_only = 1'b0;
  logic        done, timeout_err, rst_ack, mod_rst, mod_clk_en;

  int checks = 0, fails = 0;
  int cyc = 0, hi_cnt = 0, ack_delay = 0;
  bit ack_block = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc    <= cyc + 1;
    hi_cnt <= mod_rst ? hi_cnt + 1 : 0;
  end
  // stand-in for the downstream module: acknowledges reset after a lag
  assign rst_ack = !ack_block && mod_rst && (hi_cnt >= ack_delay);

  modrst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start(start),
    .enable_only(enable_only), .done(done), .timeout_err(timeout_err),
    .rst_ack(rst_ack), .mod_rst(mod_rst), .mod_clk_en(mod_clk_en)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic prep_srst(input int s);
    if (s != 0) bwrite(4'h4, 32'h8000_0000);
    else        bwrite(4'h8, 32'h8000_0000);
    repeat (6) @(negedge clk);
  endtask

  task automatic run_seq(input bit eo, input int s, input int d);
    int t0, k;
    bit rose, prev;
    ack_delay = d;
    k = eo ? 7 + s : 13 + s + d;
    @(negedge clk);
    start = 1'b1; enable_only = eo; t0 = cyc + 1; prev = mod_rst; rose = 0;
    @(negedge clk);
    start = 1'b0;
    chk(timeout_err == 1'b0, "R8 flag cleared by start", timeout_err, 0);
    while (!done && cyc < t0 + 300) begin
      if (mod_rst && !prev) rose = 1;
      prev = mod_rst;
      @(negedge clk);
    end
    if (eo) chk(cyc - t0 == k, "R6 enable-only done edge", cyc - t0, k);
    else    chk(cyc - t0 == k, "R5 full done edge", cyc - t0, k);
    if (eo) chk(!rose, "R6 no reset pulse", rose, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
    chk(bus_rdata == 32'h0, "R7 bits clear", bus_rdata, 0);
    chk(mod_rst == 1'b0 && mod_clk_en == 1'b1, "R7 module enabled",
        {mod_rst, mod_clk_en}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int t0, k;
    repeat (3) @(negedge clk);
    chk(bus_rdata == 32'hC000_0000, "R1 reset readback", bus_rdata, 32'hC000_0000);
    chk(mod_rst == 1 && mod_clk_en == 0 && done == 0 && timeout_err == 0,
        "R1 reset outputs", {mod_rst, mod_clk_en, done, timeout_err}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 alias writes (acknowledge withheld)
    bwrite(4'h8, 32'h4000_0000);
    chk(bus_rdata == 32'h8000_0000, "R2 clear alias", bus_rdata, 32'h8000_0000);
    chk(mod_clk_en == 1'b1, "R2 clock enable", mod_clk_en, 1);
    bwrite(4'h4, 32'h4000_0000);
    chk(bus_rdata == 32'hC000_0000, "R2 set alias", bus_rdata, 32'hC000_0000);
    bwrite(4'h0, 32'h0000_FFFF);
    for (int i = 0; i < 4; i++) begin
      chk(bus_rdata[31] == (i < 3), "R3 settle readback", bus_rdata[31], i < 3);
      chk(bus_rdata[30] == 1'b0, "R2 direct write gate", bus_rdata[30], 0);
      chk(bus_rdata[29:0] == '0, "R2 other bits zero", bus_rdata[29:0], 0);
      @(negedge clk);
    end
    chk(mod_rst == 1'b0, "R2 mod_rst follows", mod_rst, 0);
    bwrite(4'h0, 32'h4000_0000);
    chk(bus_rdata == 32'h4000_0000, "R2 direct write", bus_rdata, 32'h4000_0000);
    bwrite(4'h4, 32'h8000_0000);
    chk(bus_rdata == 32'hC000_0000, "R2 set alias keeps", bus_rdata, 32'hC000_0000);
    bwrite(4'hC, 32'h0000_0000);
    chk(bus_rdata == 32'hC000_0000 && mod_rst == 1, "R2 offset C no effect",
        bus_rdata, 32'hC000_0000);

    // R4 hardware gate set
    bwrite(4'h8, 32'h4000_0000);
    chk(bus_rdata == 32'h8000_0000, "R4 gate cleared w/o ack", bus_rdata, 32'h8000_0000);
    ack_delay = 0; ack_block = 1'b0;
    @(negedge clk);
    chk(bus_rdata[30] == 1'b1, "R4 hw sets gate", bus_rdata[30], 1);
    bwrite(4'h8, 32'h4000_0000);
    chk(bus_rdata[30] == 1'b1, "R4 hw beats clear", bus_rdata[30], 1);

    // R8/R9 timeout with withheld acknowledge
    ack_block = 1'b1;
    prep_srst(3);
    @(negedge clk);
    start = 1'b1; enable_only = 1'b0; t0 = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    bwrite(4'h8, 32'hC000_0000);
    chk(bus_rdata[31] == 1'b1 && mod_rst == 1'b1, "R9 write ignored busy",
        bus_rdata[31], 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    k = 4 + 3 + LIMIT;
    while (!timeout_err && !done && cyc < t0 + 2000) @(negedge clk);
    chk(cyc - t0 == k, "R8 timeout edge (R9 start ignored)", cyc - t0, k);
    chk(done == 1'b0, "R8 no done", done, 0);
    repeat (5) @(negedge clk);
    chk(timeout_err == 1'b1, "R8 flag sticky", timeout_err, 1);
    ack_block = 1'b0;

    // R5/R6 sweep over mode, initial reset state and acknowledge lag
    for (int eo = 0; eo < 2; eo++)
      for (int s = 0; s <= 3; s += 3)
        for (int d = 0; d < 5; d++) begin
          prep_srst(s);
          run_seq(eo[0], s, d);
        end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule